// File: doc/BRIEF.md
# Fractional-Duty Data Inversion Selector

This block decides, once per update slot, whether a downstream data-inversion function is enabled. Slots come in a fixed repeating cycle of eleven. An external strobe marks each slot boundary. A control word is written over a small register port, and the place of the single cleared bit in that word sets the fraction of each cycle in which inversion is selected. A zero in a low position enables inversion in most slots. A zero in a high position enables it in only a few.

The selection rule is a scan of the low bits of the word. In slot position p (0 to 10), the block looks at word bits p down to 0. It selects inversion when any of those bits is zero. Because of this rule, a word that is all zeros (the reset value) selects inversion in every slot, and a word that is all ones never selects it.

A written word is held pending and is only applied at the next slot boundary, so the decision for the current slot cannot glitch. The block also gives a conditioned copy of one input data bit. That copy is the data bit XORed with the current select flag, registered once.

Top module: `dinv_selector`

## Requirements
- R1: During and straight after synchronous reset, `inv_sel` is 1, `data_out` is 0, the slot position is 0 and both the pending and applied control words are all zeros.
- R2: Each cycle with `slot_adv` high moves the slot position by one, modulo 11: position 10 is followed by position 0.
- R3: With exactly one zero at bit k (k from 1 to 10) applied, `inv_sel` is 1 in slot positions k to 10 and 0 in positions 0 to k-1, which gives 11-k selected slots in every 11.
- R4: With bit 0 of the applied word equal to 0 (including the all-zeros word), `inv_sel` is 1 in every slot.
- R5: With the applied word all ones (11'h7FF), `inv_sel` is 0 in every slot.
- R6: With several zero bits, only the lowest zero bit z counts: `inv_sel` is 1 exactly in positions p >= z.
- R7: A write (`wr_en` high, word on `wr_data`) has no effect on `inv_sel` until the next `slot_adv`. `inv_sel` changes only on the clock edge where `slot_adv` is high.
- R8: `data_out` equals `data_in XOR inv_sel` as sampled on the previous clock edge.
- R9: A write in the same cycle as `slot_adv` is not applied by that boundary. The boundary applies the word that was pending before it, and the new word is applied at the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 11 | Control word to hold pending |
| slot_adv | input | 1 | Slot boundary strobe |
| data_in | input | 1 | Data bit to be conditionally inverted |
| inv_sel | output | 1 | Inversion selected for the current slot |
| data_out | output | 1 | Registered `data_in XOR inv_sel` |

## Verification
Every slot position is tried with the all-zeros word, with each of the eleven single-zero words and with the all-ones word. This sets the zero position, which moves the threshold, apart from the slot counter phase. Words with more than one zero show whether the lowest zero alone decides, or whether a higher zero leaks in. Writes made between boundaries, and a write made in the same cycle as a boundary, separate the pending stage from the applied word. Both data polarities under both select states confirm the XOR and its one-cycle delay.

// File: rtl/dinv_pkg.sv
package dinv_pkg;

    // Number of update slots in one repeating cycle.
    localparam int unsigned DINV_SLOTS = 11;

    // Registered output pair of the block.
    typedef struct packed {
        logic sel;
        logic dat;
    } dinv_out_t;

    // Slot position that follows cur in a cycle whose last position is last.
    function automatic int unsigned slot_after(input int unsigned cur,
                                               input int unsigned last);
        if (cur >= last) begin
            return 0;
        end
        return cur + 1;
    endfunction

endpackage

// File: rtl/dinv_mask_stage.sv
module dinv_mask_stage #(
    parameter int unsigned W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         slot_adv,
    output logic [W-1:0] pend_mask,
    output logic [W-1:0] act_next,
    output logic [W-1:0] act_mask
);

    // A boundary applies the word that was pending before it.
    always_comb begin
        act_next = slot_adv ? pend_mask : act_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_mask <= '0;
            act_mask  <= '0;
        end else begin
            if (wr_en) begin
                pend_mask <= wr_data;
            end
            act_mask <= act_next;
        end
    end

endmodule

// File: rtl/dinv_slot_counter.sv
module dinv_slot_counter
    import dinv_pkg::*;
#(
    parameter int unsigned SLOTS = DINV_SLOTS,
    parameter int unsigned CW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_adv,
    output logic [CW-1:0] slot_next,
    output logic [CW-1:0] slot_idx
);

    localparam int unsigned LAST = SLOTS - 1;

    always_comb begin
        if (slot_adv) begin
            slot_next = CW'(slot_after(int'(slot_idx), LAST));
        end else begin
            slot_next = slot_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_idx <= '0;
        end else begin
            slot_idx <= slot_next;
        end
    end

endmodule

// File: rtl/dinv_zero_scan.sv
module dinv_zero_scan #(
    parameter int unsigned W  = 11,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    input  logic [CW-1:0] pos,
    output logic          sel
);

    // zero_seen[i] is high when any of mask[i:0] is zero.
    logic [W-1:0] zero_seen;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_scan
            if (gi == 0) begin : g_first
                assign zero_seen[gi] = ~mask[gi];
            end else begin : g_rest
                assign zero_seen[gi] = zero_seen[gi-1] | ~mask[gi];
            end
        end
    endgenerate

    always_comb begin
        sel = 1'b0;
        for (int i = 0; i < int'(W); i++) begin
            if (pos == CW'(i)) begin
                sel = zero_seen[i];
            end
        end
    end

endmodule

// File: rtl/dinv_selector.sv
module dinv_selector
    import dinv_pkg::*;
#(
    parameter int unsigned SLOTS = DINV_SLOTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SLOTS-1:0] wr_data,
    input  logic             slot_adv,
    input  logic             data_in,
    output logic             inv_sel,
    output logic             data_out
);

    localparam int unsigned CW = $clog2(SLOTS);

    logic [SLOTS-1:0] pend_mask;
    logic [SLOTS-1:0] act_next;
    logic [SLOTS-1:0] act_mask;
    logic [CW-1:0]    slot_next;
    logic [CW-1:0]    slot_idx;
    logic             sel_next;
    dinv_out_t        out_q;

    dinv_mask_stage #(.W(SLOTS)) i_mask (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .slot_adv  (slot_adv),
        .pend_mask (pend_mask),
        .act_next  (act_next),
        .act_mask  (act_mask)
    );

    dinv_slot_counter #(.SLOTS(SLOTS), .CW(CW)) i_count (
        .clk       (clk),
        .rst       (rst),
        .slot_adv  (slot_adv),
        .slot_next (slot_next),
        .slot_idx  (slot_idx)
    );

    // Decision for the slot that starts after this edge.
    dinv_zero_scan #(.W(SLOTS), .CW(CW)) i_scan (
        .mask (act_next),
        .pos  (slot_next),
        .sel  (sel_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.sel <= 1'b1;
            out_q.dat <= 1'b0;
        end else begin
            out_q.sel <= sel_next;
            out_q.dat <= data_in ^ out_q.sel;
        end
    end

    assign inv_sel  = out_q.sel;
    assign data_out = out_q.dat;

endmodule

// File: rtl/dinv_selector_chk.sv
module dinv_selector_chk #(
    parameter int unsigned SLOTS = 11,
    parameter int unsigned CW    = $clog2(SLOTS)
) (
    input logic             clk,
    input logic             rst,
    input logic             slot_adv,
    input logic             data_in,
    input logic             inv_sel,
    input logic             data_out,
    input logic [SLOTS-1:0] pend_mask,
    input logic [CW-1:0]    slot_idx
);

    // R1: select flag is 1 on the first cycle out of reset
    assert_reset_sel_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> inv_sel);

    // R2: slot position stays in range and wraps to 0
    assert_slot_range_R2: assert property (@(posedge clk) disable iff (rst)
        slot_idx <= CW'(SLOTS - 1));
    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (slot_adv && slot_idx == CW'(SLOTS - 1)) |=> slot_idx == '0);

    // R4: low bit zero forces selection
    assert_low_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (slot_adv && !pend_mask[0]) |=> inv_sel);

    // R5: all-ones word never selects
    assert_all_ones_R5: assert property (@(posedge clk) disable iff (rst)
        (slot_adv && (&pend_mask)) |=> !inv_sel);

    // R7: no change without a boundary
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !slot_adv |=> $stable(inv_sel));

    // R8: data output is last cycle's input XOR select flag
    assert_data_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> data_out == ($past(data_in) ^ $past(inv_sel)));

endmodule

bind dinv_selector dinv_selector_chk #(.SLOTS(SLOTS), .CW(CW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .slot_adv  (slot_adv),
    .data_in   (data_in),
    .inv_sel   (inv_sel),
    .data_out  (data_out),
    .pend_mask (pend_mask),
    .slot_idx  (slot_idx)
);

// File: tb/test_dinv_selector.sv
module test_dinv_selector;

    localparam int N = 11;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [N-1:0] wr_data = '0;
    logic         slot_adv = 1'b0;
    logic         data_in = 1'b0;
    logic         inv_sel;
    logic         data_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [N-1:0] pend_m = '0;
    logic [N-1:0] act_m = '0;
    int           pos_m = 0;

    always #5 clk = ~clk;

    dinv_selector i_dinv_selector (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .slot_adv (slot_adv),
        .data_in  (data_in),
        .inv_sel  (inv_sel),
        .data_out (data_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (pos %0d word %h)", req, act, exp, pos_m, act_m);
        end
    endtask

    function automatic int lowest_zero(input logic [N-1:0] m);
        for (int i = 0; i < N; i++) begin
            if (m[i] == 1'b0) return i;
        end
        return N;
    endfunction

    function automatic int zero_count(input logic [N-1:0] m);
        int c = 0;
        for (int i = 0; i < N; i++) if (m[i] == 1'b0) c++;
        return c;
    endfunction

    function automatic logic exp_sel();
        return (pos_m >= lowest_zero(act_m)) ? 1'b1 : 1'b0;
    endfunction

    task automatic write_word(input logic [N-1:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        pend_m = w;
    endtask

    // One boundary, optionally with a write in the same cycle (R9).
    task automatic boundary(input logic do_wr, input logic [N-1:0] w);
        @(negedge clk);
        slot_adv = 1'b1;
        wr_en = do_wr;
        wr_data = w;
        @(negedge clk);
        slot_adv = 1'b0;
        wr_en = 1'b0;
        act_m = pend_m;
        if (do_wr) pend_m = w;
        pos_m = (pos_m + 1) % N;
    endtask

    task automatic data_check(input logic d);
        @(negedge clk);
        data_in = d;
        @(negedge clk);
        check("R8", data_out, d ^ inv_sel);
    endtask

    task automatic run_word(input logic [N-1:0] w, input string tag);
        int hits = 0;
        int z;
        write_word(w);
        z = lowest_zero(w);
        for (int s = 0; s < N; s++) begin
            boundary(1'b0, '0);
            check(tag, inv_sel, exp_sel());
            if (inv_sel === 1'b1) hits++;
            if (s == 3) begin
                data_check(1'b1);
                data_check(1'b0);
            end
        end
        checks++;
        if (hits != N - z) begin
            errors++;
            $display("FAIL %s: selected %0d of %0d expected %0d", tag, hits, N, N - z);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] w;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset, before the next edge
        check("R1", inv_sel, 1'b1);
        check("R1", data_out, 1'b0);
        @(negedge clk);
        check("R1", inv_sel, 1'b1);

        // Sweep: all zeros, each single zero, all ones, multi-zero words
        for (int p = 0; p < N + 5; p++) begin
            if (p == 0) w = '0;
            else if (p <= N) w = ~(N'(1) << (p - 1));
            else if (p == N + 1) w = '1;
            else if (p == N + 2) w = 11'h7F3;
            else if (p == N + 3) w = 11'h5EF;
            else w = 11'h3FE;
            if (lowest_zero(w) == N) tag = "R5";
            else if (lowest_zero(w) == 0) tag = "R4";
            else if (zero_count(w) > 1) tag = "R6";
            else tag = "R3";
            run_word(w, tag);
        end

        // R2: zero at bit 10 selects only at position 10, then wraps to 0
        run_word(11'h3FF, "R2");
        while (pos_m != N - 1) boundary(1'b0, '0);
        check("R2", inv_sel, 1'b1);
        boundary(1'b0, '0);
        check("R2", inv_sel, 1'b0);
        check("R2", pos_m == 0, 1'b1);

        // R7: writes between boundaries do not move the flag
        write_word('1);
        boundary(1'b0, '0);
        check("R7", inv_sel, 1'b0);
        write_word('0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check("R7", inv_sel, 1'b0);
        end
        boundary(1'b0, '0);
        check("R7", inv_sel, 1'b1);

        // R9: write coincident with boundary applies one boundary later
        write_word('1);
        boundary(1'b0, '0);
        check("R9", inv_sel, 1'b0);
        boundary(1'b1, '0);
        check("R9", inv_sel, 1'b0);
        boundary(1'b0, '0);
        check("R9", inv_sel, 1'b1);

        // R8: both polarities under both select states
        data_check(1'b1);
        data_check(1'b0);
        write_word('1);
        boundary(1'b0, '0);
        data_check(1'b1);
        data_check(1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule